// File: doc/BRIEF.md
# Interrupt Enable and Pending Register Bank

This block keeps one enable flag and one pending flag for each of a configurable number of interrupt lines, up to 128. Software reaches the flags through four register views. Each view has up to four 32-bit words, and bit b of word w stands for line 32*w+b. Enable and pending state each have a write-one-to-set view and a write-one-to-clear view. Both views of a pair read back the same flags, so software can change single lines with no read-modify-write.

Hardware request lines also raise pending flags. A rising edge on a request line sets the pending flag of that line, whether or not the line is enabled. A line can therefore wait in the pending state while it is disabled, and it is presented as soon as software enables it. For each line the block drives a registered request output, the AND of its enable and pending flags, to a downstream arbiter.

The register port is a plain synchronous bus with select, write-enable, a word address and 32-bit data, so it has no stream back-pressure. A read is accepted in the cycle in which select is high and write-enable is low. Its data appears on the read-data output after the next clock edge and stays there until the next read.

Top module: `irq_regs`

## Requirements
- R1: After reset, every enable flag, every pending flag, every request output bit and the read-data output are 0.
- R2: Address bits [3:2] select the view and bits [1:0] select the word. In view 0 (enable-set), a 1 written to a bit enables that line and a 0 leaves it unchanged. Reading view 0 returns the enable flags.
- R3: In view 1 (enable-clear), a 1 written to a bit disables that line and a 0 leaves it unchanged. Reading view 1 also returns the enable flags.
- R4: In view 2 (pending-set), a 1 written to a bit makes that line pending even if the line is disabled, and a 0 leaves it unchanged. A line that is already pending stays pending. Reading view 2 returns the pending flags.
- R5: In view 3 (pending-clear), a 1 written to a bit removes the pending state of that line and a 0 leaves it unchanged. Reading view 3 also returns the pending flags.
- R6: A 0-to-1 transition on a request input, seen at a clock edge, sets the pending flag of that line in the same edge, whether or not the line is enabled. A request input held high does not set the flag again after it has been cleared.
- R7: When a clear of a pending flag and a set of the same flag (a hardware edge or a pending-set write) fall in the same cycle, the flag ends up set.
- R8: Each request output bit equals the AND of the enable and pending flags of its line as they stood one clock edge earlier.
- R9: Bits at or above the implemented line count ignore writes and read as 0. Words past the last implemented word read as 0.
- R10: Read data is loaded at the edge that ends a read cycle and holds its value through cycles without a read, writes included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | View in [3:2], word in [1:0] |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_in | input | LINES | Hardware request lines, edge-detected |
| irq_req | output | LINES | Registered enable-AND-pending per line |

## Verification
The bench builds the block with LINES set to 40. The second word is then only partly implemented, with eight live bits, and the third and fourth words are not implemented at all. This exposes the masking of high bits and of unused words. Lines in both words are exercised, so the word-select decode is tested as well as the bit decode. The set-wins case, the held-high request input and the pending-while-disabled case are each driven in their own scenario.

// File: rtl/irq_regs_pkg.sv
package irq_regs_pkg;
  localparam int WORD_W    = 32;
  localparam int WSEL_W    = 2;
  localparam int ADDR_W    = WSEL_W + 2;
  localparam int MAX_WORDS = 1 << WSEL_W;
  localparam int MAX_LINES = MAX_WORDS * WORD_W;

  typedef enum logic [1:0] {
    VIEW_EN_SET = 2'd0,
    VIEW_EN_CLR = 2'd1,
    VIEW_PD_SET = 2'd2,
    VIEW_PD_CLR = 2'd3
  } view_e;
endpackage

// File: rtl/irq_edge_detect.sv
module irq_edge_detect #(
  parameter int LINES = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] lvl,
  output logic [LINES-1:0] rise
);
  logic [LINES-1:0] lvl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) lvl_q <= '0;
    else        lvl_q <= lvl;
  end

  assign rise = lvl & ~lvl_q;
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int LINES = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] sw_set,
  input  logic [LINES-1:0] sw_clr,
  input  logic [LINES-1:0] hw_set,
  output logic [LINES-1:0] q
);
  logic [LINES-1:0] any_set;

  assign any_set = sw_set | hw_set;

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= (q & ~sw_clr) | any_set;
  end

  // R7
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (any_set != '0) |=> ((q & $past(any_set)) == $past(any_set)));

  // R5
  clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_clr != '0) |=> ((q & $past(sw_clr & ~any_set)) == '0));

  // R4
  no_stray_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((q & ~$past(q) & ~$past(any_set)) == '0));
endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import irq_regs_pkg::*;
#(
  parameter int LINES = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic [LINES-1:0]  irq_in,
  output logic [LINES-1:0]  irq_req
);
  localparam int WORDS = (LINES + WORD_W - 1) / WORD_W;

  initial begin
    if (LINES < 1 || LINES > MAX_LINES)
      $error("irq_regs: LINES out of range");
  end

  view_e             view;
  logic [WSEL_W-1:0] wsel;
  logic              wr_acc, rd_acc;
  logic [LINES-1:0]  wmask, rise, en_q, pd_q;
  logic [LINES-1:0]  en_set, en_clr, pd_set, pd_clr;
  logic [MAX_LINES-1:0] en_pad, pd_pad;

  assign view   = view_e'(bus_addr[ADDR_W-1:WSEL_W]);
  assign wsel   = bus_addr[WSEL_W-1:0];
  assign wr_acc = bus_sel & bus_we;
  assign rd_acc = bus_sel & ~bus_we;

  for (genvar i = 0; i < LINES; i++) begin : g_wmask
    assign wmask[i] = wr_acc && (wsel == WSEL_W'(i / WORD_W)) && bus_wdata[i % WORD_W];
  end

  assign en_set = (view == VIEW_EN_SET) ? wmask : '0;
  assign en_clr = (view == VIEW_EN_CLR) ? wmask : '0;
  assign pd_set = (view == VIEW_PD_SET) ? wmask : '0;
  assign pd_clr = (view == VIEW_PD_CLR) ? wmask : '0;

  irq_edge_detect #(.LINES(LINES)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(irq_in), .rise(rise)
  );

  irq_flag_bank #(.LINES(LINES)) u_enable (
    .clk(clk), .rst_n(rst_n), .sw_set(en_set), .sw_clr(en_clr),
    .hw_set('0), .q(en_q)
  );

  irq_flag_bank #(.LINES(LINES)) u_pending (
    .clk(clk), .rst_n(rst_n), .sw_set(pd_set), .sw_clr(pd_clr),
    .hw_set(rise), .q(pd_q)
  );

  for (genvar i = 0; i < MAX_LINES; i++) begin : g_pad
    if (i < LINES) begin : g_live
      assign en_pad[i] = en_q[i];
      assign pd_pad[i] = pd_q[i];
    end else begin : g_dead
      assign en_pad[i] = 1'b0;
      assign pd_pad[i] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata <= '0;
      irq_req   <= '0;
    end else begin
      irq_req <= en_q & pd_q;
      if (rd_acc) begin
        if (view == VIEW_EN_SET || view == VIEW_EN_CLR)
          bus_rdata <= en_pad[wsel*WORD_W +: WORD_W];
        else
          bus_rdata <= pd_pad[wsel*WORD_W +: WORD_W];
      end
    end
  end

  // R8
  req_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_req == $past(en_q & pd_q)));

  // R6
  edge_pends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise != '0) |=> ((pd_q & $past(rise)) == $past(rise)));

  // R9
  dead_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && (int'(wsel) >= WORDS)) |=> (bus_rdata == '0));

  // R10
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_acc |=> $stable(bus_rdata));
endmodule

// File: tb/irq_regs_test.sv
module irq_regs_test;
  localparam int N = 40;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_sel = 1'b0, bus_we = 1'b0;
  logic [3:0]    bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [N-1:0]  irq_in = '0;
  logic [N-1:0]  irq_req;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [127:0] m_en = '0, m_pd = '0;

  always #10 clk = ~clk;

  irq_regs #(.LINES(N)) uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_in(irq_in), .irq_req(irq_req)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply_model(logic [1:0] v, logic [1:0] w, logic [31:0] d);
    logic [127:0] m;
    m = '0;
    m[w*32 +: 32] = d;
    m = m & ((128'd1 << N) - 128'd1);
    case (v)
      2'd0: m_en = m_en | m;
      2'd1: m_en = m_en & ~m;
      2'd2: m_pd = m_pd | m;
      default: m_pd = m_pd & ~m;
    endcase
  endtask

  task automatic wr(logic [1:0] v, logic [1:0] w, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = {v, w}; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
    apply_model(v, w, d);
  endtask

  task automatic rd_chk(string tag, logic [1:0] v, logic [1:0] w);
    logic [127:0] src;
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = {v, w};
    @(negedge clk);
    bus_sel = 1'b0;
    src = v[1] ? m_pd : m_en;
    chk(tag, 64'(bus_rdata), 64'(src[w*32 +: 32]));
  endtask

  task automatic req_chk(string tag);
    @(negedge clk);
    chk(tag, 64'(irq_req), 64'(m_en[N-1:0] & m_pd[N-1:0]));
  endtask

  task automatic t_reset;
    chk("R1 req after reset", 64'(irq_req), 64'd0);
    chk("R1 rdata after reset", 64'(bus_rdata), 64'd0);
    for (int w = 0; w < 2; w++) begin
      rd_chk("R1 enable reset", 2'd0, 2'(w));
      rd_chk("R1 pending reset", 2'd2, 2'(w));
    end
  endtask

  task automatic t_enable;
    wr(2'd0, 2'd0, 32'h8000_0011);
    rd_chk("R2 enable-set word0", 2'd0, 2'd0);
    wr(2'd0, 2'd1, 32'h0000_0042);
    wr(2'd0, 2'd0, 32'h0000_0000);
    rd_chk("R2 zero write no effect", 2'd0, 2'd0);
    rd_chk("R3 enable read via clear view", 2'd1, 2'd1);
    wr(2'd1, 2'd0, 32'h0000_0010);
    rd_chk("R3 enable-clear word0", 2'd0, 2'd0);
    wr(2'd1, 2'd1, 32'h0000_0000);
    rd_chk("R3 zero clear no effect", 2'd1, 2'd1);
    chk("R3 model sanity", 64'(m_en[39:0]), 64'h42_8000_0001);
  endtask

  task automatic t_pending_sw;
    wr(2'd2, 2'd0, 32'h0000_0300);
    rd_chk("R4 pending while disabled", 2'd2, 2'd0);
    req_chk("R8 no req while disabled");
    wr(2'd0, 2'd0, 32'h0000_0100);
    req_chk("R8 req after enable");
    wr(2'd2, 2'd0, 32'h0000_0100);
    rd_chk("R4 re-pend unchanged", 2'd2, 2'd0);
    wr(2'd2, 2'd1, 32'h0000_0002);
    rd_chk("R4 pend word1", 2'd3, 2'd1);
    req_chk("R8 req word1 line");
    wr(2'd3, 2'd0, 32'h0000_0100);
    rd_chk("R5 clear-pending", 2'd3, 2'd0);
    req_chk("R8 req drops after clear");
    wr(2'd3, 2'd0, 32'h0000_0000);
    rd_chk("R5 zero clear no effect", 2'd2, 2'd0);
  endtask

  task automatic t_hw_edge;
    @(negedge clk);
    irq_in[20] = 1'b1; irq_in[36] = 1'b1;
    m_pd[20] = 1'b1; m_pd[36] = 1'b1;
    rd_chk("R6 edge sets disabled line", 2'd2, 2'd0);
    rd_chk("R6 edge sets word1 line", 2'd2, 2'd1);
    wr(2'd3, 2'd0, 32'h0010_0000);
    rd_chk("R6 held level no re-set", 2'd2, 2'd0);
    @(negedge clk);
    irq_in[20] = 1'b0;
    @(negedge clk);
    irq_in[20] = 1'b1; m_pd[20] = 1'b1;
    rd_chk("R6 second edge sets again", 2'd2, 2'd0);
    irq_in = '0;
  endtask

  task automatic t_set_wins;
    wr(2'd2, 2'd0, 32'h0000_0020);
    @(negedge clk);
    irq_in[5] = 1'b1;
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = {2'd3, 2'd0}; bus_wdata = 32'h0000_0020;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
    rd_chk("R7 hw set beats sw clear", 2'd2, 2'd0);
    irq_in[5] = 1'b0;
    wr(2'd3, 2'd0, 32'h0000_0020);
    rd_chk("R7 clear works alone", 2'd2, 2'd0);
  endtask

  task automatic t_range;
    wr(2'd0, 2'd1, 32'hFFFF_FFFF);
    rd_chk("R9 high bits ignored enable", 2'd0, 2'd1);
    chk("R9 readback masked", 64'(m_en[63:32]), 64'h0000_00FF);
    wr(2'd2, 2'd2, 32'hFFFF_FFFF);
    rd_chk("R9 dead word pending", 2'd2, 2'd2);
    rd_chk("R9 dead word enable", 2'd0, 2'd3);
    rd_chk("R9 word1 pending unaffected", 2'd2, 2'd1);
    req_chk("R8 req after range writes");
  endtask

  task automatic t_hold;
    logic [31:0] held;
    rd_chk("R10 read before hold", 2'd0, 2'd0);
    held = bus_rdata;
    wr(2'd1, 2'd0, 32'hFFFF_FFFF);
    @(negedge clk);
    chk("R10 rdata held across write", 64'(bus_rdata), 64'(held));
    rd_chk("R10 new read updates", 2'd0, 2'd0);
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        checks++; errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_enable();
    t_pending_sw();
    t_hw_edge();
    t_set_wins();
    t_range();
    t_hold();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule